// File: doc/BRIEF.md
# Interval Timer Bank with Acknowledge-on-Read

This block holds a set of interval timers for a small multiprocessor: one timer per processor plus one shared system timer. Each timer has a counter that advances on an enable tick, a limit that sets the period, and a pending flag that drives an interrupt request line. When the count equals a nonzero limit, the next tick wraps the count to zero and sets the pending flag. The flag stays set until software acknowledges it, and reading the limit word is what acknowledges it.

A second write port into the limit lets software reprogram the period without losing a pending event. A limit of zero turns off the periodic interrupt. A mode word in the system timer's region can take any processor timer out of compare mode. Software reaches every register over a word-wide bus. Writes and reads take effect at the clock edge, and the read data is combinational from the address.

Top module: `itmr_bank`

## Requirements
- R1: The word address map places processor timer i at words 4i..4i+3 as (limit, count, limit-keep, start/stop) and the system timer at words 4N..4N+4 as (limit, count, limit-keep, reserved, mode), where N is the processor count. The start/stop and reserved words read 0 and ignore writes. The limit-keep words read 0. Addresses outside the map read 0.
- R2: A timer's count goes up by one on each clock edge where `tick_en` is 1, and holds when it is 0. It wraps modulo 2^CNT_W.
- R3: With a nonzero limit L, a tick that finds the count equal to L loads 0 into the count and sets the pending flag, so one period is L+1 ticks.
- R4: A read of a limit word returns the pending flag in bit DATA_W-1 and the limit in bits CNT_W-1:0, and it clears that timer's pending flag at that edge.
- R5: A read of a count word returns the pending flag in bit DATA_W-1 and the count in bits CNT_W-1:0, and it changes no state.
- R6: A write to a limit word loads the limit from `bus_wdata[CNT_W-1:0]`, sets the count to 0 and clears the pending flag.
- R7: A write to a limit-keep word loads the limit and sets the count to 0, and it leaves the pending flag as it was.
- R8: While a timer's limit is 0, its pending flag never sets and its count runs freely.
- R9: If a wrap and a limit-word read acknowledge fall on the same edge, the flag ends up set. If a wrap and a limit or limit-keep write fall on the same edge, the write wins and the wrap does not happen.
- R10: Bit i of the mode word (bits N-1:0, reading back as written) set to 1 stops processor timer i from raising its flag while its count keeps running. Writing 0 puts every processor timer in compare mode.
- R11: After reset every count, limit, pending flag and mode bit is 0, and every interrupt output is low.
- R12: `cpu_irq[i]` follows the pending flag of processor timer i, and `sys_irq` follows the system timer's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable tick, shared by all timers |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (ignored when bus_wr is 1) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_rd is 1 |
| cpu_irq | output | NUM_CPU | Per-processor timer interrupt requests |
| sys_irq | output | 1 | System timer interrupt request |

## Verification
Two functions can fall on the same edge: the tick that wraps a timer, and a bus access to that timer's limit. The bench parks a timer exactly at its limit, then issues a limit read with `tick_en` high. The read data must show the old flag clear, and both the interrupt line and a follow-up limit read must show the flag set. It repeats this with a limit write instead, where the count must be 0 and the flag clear. Period behaviour is swept over every timer, several limits and every tick count up to past two periods, with the count and flag predicted as K mod (L+1) and K ≥ L+1.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

   // Word offsets inside one timer's register window.
   localparam logic [2:0] W_LIM  = 3'd0;
   localparam logic [2:0] W_CNT  = 3'd1;
   localparam logic [2:0] W_KEEP = 3'd2;
   localparam logic [2:0] W_AUX  = 3'd3;
   localparam logic [2:0] W_MODE = 3'd4;

   localparam int CPU_SPAN = 4;   // words per processor timer
   localparam int SYS_SPAN = 5;   // words in the system timer window

   // Action a bus access requests from one timer.
   typedef struct packed {
      logic ld_clr;   // limit write, flag cleared
      logic ld_keep;  // limit write, flag kept
      logic ack;      // limit read acknowledge
   } tmr_cmd_t;

endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
   import itmr_pkg::*;
#(
   parameter int NUM_CPU = 2,
   parameter int ADDR_W  = 4,
   localparam int NU     = NUM_CPU + 1,
   localparam int UW     = (NU > 1) ? $clog2(NU) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   output tmr_cmd_t          cmd [NU],
   output logic              mode_wr,
   output logic              rd_hit,
   output logic [UW-1:0]     rd_unit,
   output logic [2:0]        rd_word
);

   localparam int MAP_END = NUM_CPU * CPU_SPAN + SYS_SPAN;

   generate
      if ((1 << ADDR_W) < MAP_END) begin : g_bad_addr
         $error("itmr_decode: ADDR_W too small for the register map");
      end
   endgenerate

   logic          hit;
   logic [UW-1:0] unit;
   logic [2:0]    word;
   logic          rd_ok;

   always_comb begin
      hit  = 1'b0;
      unit = '0;
      word = '0;
      for (int u = 0; u < NU; u++) begin
         int base;
         int span;
         base = u * CPU_SPAN;
         span = (u == NUM_CPU) ? SYS_SPAN : CPU_SPAN;
         if (int'(bus_addr) >= base && int'(bus_addr) < base + span) begin
            hit  = 1'b1;
            unit = UW'(u);
            word = 3'(int'(bus_addr) - base);
         end
      end
   end

   assign rd_ok   = bus_rd && !bus_wr;
   assign rd_hit  = hit;
   assign rd_unit = unit;
   assign rd_word = word;

   genvar gu;
   generate
      for (gu = 0; gu < NU; gu++) begin : g_strobe
         logic sel;
         assign sel = hit && (unit == UW'(gu));
         assign cmd[gu].ld_clr  = bus_wr && sel && (word == W_LIM);
         assign cmd[gu].ld_keep = bus_wr && sel && (word == W_KEEP);
         assign cmd[gu].ack     = rd_ok  && sel && (word == W_LIM);
      end
   endgenerate

   assign mode_wr = bus_wr && hit && (unit == UW'(NUM_CPU)) && (word == W_MODE);

   // At most one timer action or mode write per access.
   logic [3*NU:0] all_str;
   always_comb begin
      all_str = '0;
      for (int u = 0; u < NU; u++) begin
         all_str[3*u]   = cmd[u].ld_clr;
         all_str[3*u+1] = cmd[u].ld_keep;
         all_str[3*u+2] = cmd[u].ack;
      end
      all_str[3*NU] = mode_wr;
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(all_str)); // R1

endmodule

// File: rtl/itmr_unit.sv
module itmr_unit
   import itmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cmp_en,
   input  tmr_cmd_t         cmd,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] lim_o,
   output logic             pend_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_q;
   logic             pend_q;
   logic             load;
   logic             at_lim;
   logic             wrap;

   assign load   = cmd.ld_clr || cmd.ld_keep;
   assign at_lim = (lim_q != '0) && (cnt_q == lim_q);
   assign wrap   = tick && cmp_en && at_lim && !load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         lim_q  <= '0;
         pend_q <= 1'b0;
      end else if (load) begin
         lim_q <= ld_val;
         cnt_q <= '0;
         if (cmd.ld_clr) pend_q <= 1'b0;
      end else begin
         if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
         if (wrap)         pend_q <= 1'b1;
         else if (cmd.ack) pend_q <= 1'b0;
      end
   end

   assign cnt_o  = cnt_q;
   assign lim_o  = lim_q;
   assign pend_o = pend_q;

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt_q)); // R2
   AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (pend_q && cnt_q == '0)); // R3
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.ack && !tick) |=> !pend_q); // R4
   AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.ld_clr |=> (cnt_q == '0 && !pend_q)); // R6
   AST_KEEP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.ld_keep |=> (pend_q == $past(pend_q) && cnt_q == '0)); // R7
   AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_q == '0 && !pend_q) |=> !pend_q); // R8
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && cmd.ack) |=> pend_q); // R9

endmodule

// File: rtl/itmr_bank.sv
module itmr_bank
   import itmr_pkg::*;
#(
   parameter int NUM_CPU = 2,
   parameter int CNT_W   = 22,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = $clog2(NUM_CPU * 4 + 5)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [NUM_CPU-1:0] cpu_irq,
   output logic               sys_irq
);

   localparam int NU = NUM_CPU + 1;
   localparam int UW = (NU > 1) ? $clog2(NU) : 1;

   generate
      if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_ncpu
         $error("itmr_bank: NUM_CPU must be 1..8");
      end
      if (CNT_W < 2 || CNT_W > DATA_W - 1) begin : g_bad_cnt
         $error("itmr_bank: CNT_W must be 2..DATA_W-1");
      end
      if (NUM_CPU > DATA_W) begin : g_bad_mode
         $error("itmr_bank: mode word narrower than NUM_CPU");
      end
   endgenerate

   tmr_cmd_t          cmd [NU];
   logic              mode_wr;
   logic              rd_hit;
   logic [UW-1:0]     rd_unit;
   logic [2:0]        rd_word;
   logic [NUM_CPU-1:0] mode_q;

   logic [CNT_W-1:0]  cnt_a  [NU];
   logic [CNT_W-1:0]  lim_a  [NU];
   logic              pend_a [NU];

   itmr_decode #(
      .NUM_CPU (NUM_CPU),
      .ADDR_W  (ADDR_W)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_wr  (bus_wr),
      .bus_rd  (bus_rd),
      .bus_addr(bus_addr),
      .cmd     (cmd),
      .mode_wr (mode_wr),
      .rd_hit  (rd_hit),
      .rd_unit (rd_unit),
      .rd_word (rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_wr) mode_q <= bus_wdata[NUM_CPU-1:0];
   end

   genvar gu;
   generate
      for (gu = 0; gu < NU; gu++) begin : g_tmr
         logic cmp_en;
         if (gu < NUM_CPU) begin : g_cpu
            assign cmp_en      = !mode_q[gu];
            assign cpu_irq[gu] = pend_a[gu];
         end else begin : g_sys
            assign cmp_en  = 1'b1;
            assign sys_irq = pend_a[gu];
         end
         itmr_unit #(
            .CNT_W (CNT_W)
         ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_en),
            .cmp_en (cmp_en),
            .cmd    (cmd[gu]),
            .ld_val (bus_wdata[CNT_W-1:0]),
            .cnt_o  (cnt_a[gu]),
            .lim_o  (lim_a[gu]),
            .pend_o (pend_a[gu])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && rd_hit) begin
         case (rd_word)
            W_LIM: begin
               bus_rdata[CNT_W-1:0] = lim_a[rd_unit];
               bus_rdata[DATA_W-1]  = pend_a[rd_unit];
            end
            W_CNT: begin
               bus_rdata[CNT_W-1:0] = cnt_a[rd_unit];
               bus_rdata[DATA_W-1]  = pend_a[rd_unit];
            end
            W_MODE: bus_rdata[NUM_CPU-1:0] = mode_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[0] && !cpu_irq[0]) |=> !cpu_irq[0]); // R10
   AST_RESET_LOW: assert property (@(posedge clk)
      !rst_n |=> (cpu_irq == '0 && !sys_irq)); // R11

endmodule

// File: tb/sim_itmr_bank.sv
module sim_itmr_bank;

   localparam int CLK_P   = 10;
   localparam int NUM_CPU = 2;
   localparam int CNT_W   = 8;
   localparam int DATA_W  = 32;
   localparam int ADDR_W  = 4;
   localparam int NU      = NUM_CPU + 1;
   localparam int MSB     = DATA_W - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_en = 1'b0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic [NUM_CPU-1:0] cpu_irq;
   logic              sys_irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   itmr_bank #(
      .NUM_CPU(NUM_CPU), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_irq(cpu_irq), .sys_irq(sys_irq)
   );

   task automatic chk(input string req, input logic [DATA_W-1:0] act,
                      input logic [DATA_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One bus cycle; tk raises tick_en on the same edge.
   task automatic op(input logic wr, input logic rd, input int addr,
                     input logic [DATA_W-1:0] wd, input logic tk,
                     output logic [DATA_W-1:0] rd_o);
      @(negedge clk);
      bus_wr = wr; bus_rd = rd; bus_addr = ADDR_W'(addr);
      bus_wdata = wd; tick_en = tk;
      #1 rd_o = bus_rdata;
      @(posedge clk);
      #1;
      bus_wr = 1'b0; bus_rd = 1'b0; tick_en = 1'b0;
   endtask

   task automatic wr(input int addr, input logic [DATA_W-1:0] wd);
      logic [DATA_W-1:0] d;
      op(1'b1, 1'b0, addr, wd, 1'b0, d);
   endtask

   task automatic rd(input int addr, output logic [DATA_W-1:0] d);
      op(1'b0, 1'b1, addr, '0, 1'b0, d);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_en = 1'b1;
         @(posedge clk);
         #1 tick_en = 1'b0;
      end
   endtask

   function automatic logic irq_of(input int u);
      return (u < NUM_CPU) ? cpu_irq[u] : sys_irq;
   endfunction

   function automatic logic [DATA_W-1:0] fmt(input logic p, input int v);
      logic [DATA_W-1:0] r;
      r = DATA_W'(v);
      r[MSB] = p;
      return r;
   endfunction

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [DATA_W-1:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11: reset state
      @(negedge clk);
      chk("R11 irq", {30'd0, cpu_irq, sys_irq}, '0);
      for (int u = 0; u < NU; u++) begin
         rd(4*u + 1, d); chk("R11 count", d, '0);
         rd(4*u, d);     chk("R11 limit", d, '0);
      end
      rd(12, d); chk("R11 mode", d, '0);

      // R2: no tick, count holds; with limit 0 it runs freely
      wr(0, 0);
      ticks(5);
      repeat (4) @(negedge clk);
      rd(1, d); chk("R2 hold", d, fmt(1'b0, 5));

      // R3/R4/R5/R6/R12: sweep of every timer, limits and tick counts
      for (int u = 0; u < NU; u++) begin
         for (int lim = 1; lim <= 4; lim++) begin
            for (int k = 0; k <= 2*lim + 2; k++) begin
               int  ec;
               logic ep;
               ec = k % (lim + 1);
               ep = (k >= lim + 1);
               wr(4*u, lim);
               ticks(k);
               @(negedge clk);
               chk("R12 irq line", irq_of(u), ep);
               rd(4*u + 1, d); chk("R3 count", d, fmt(ep, ec));
               rd(4*u + 1, d); chk("R5 count reread", d, fmt(ep, ec));
               rd(4*u, d);     chk("R4 limit read", d, fmt(ep, lim));
               @(negedge clk);
               chk("R4 ack clears", irq_of(u), 1'b0);
            end
         end
      end

      // R8: zero limit on system timer, 300 ticks wrap at 256
      wr(8, 0);
      ticks(300);
      @(negedge clk);
      chk("R8 no irq", sys_irq, 1'b0);
      rd(9, d); chk("R8 free run", d, fmt(1'b0, 300 % 256));

      // R7: keep alias preserves flag, R6: limit write clears it
      wr(4, 2);
      ticks(3);
      @(negedge clk);
      chk("R7 setup", cpu_irq[1], 1'b1);
      wr(6, 5);
      @(negedge clk);
      chk("R7 flag kept", cpu_irq[1], 1'b1);
      rd(5, d); chk("R7 count restart", d, fmt(1'b1, 0));
      ticks(4);
      rd(5, d); chk("R7 new limit", d, fmt(1'b1, 4));
      wr(4, 5);
      @(negedge clk);
      chk("R6 flag cleared", cpu_irq[1], 1'b0);

      // R9: acknowledge on the wrap edge, set wins
      wr(0, 3);
      ticks(3);
      op(1'b0, 1'b1, 0, '0, 1'b1, d);
      chk("R9 read before set", d, fmt(1'b0, 3));
      @(negedge clk);
      chk("R9 set wins irq", cpu_irq[0], 1'b1);
      rd(1, d); chk("R9 count wrapped", d, fmt(1'b1, 0));
      rd(0, d); chk("R9 reread", d, fmt(1'b1, 3));
      // R9: write on the wrap edge, write wins
      wr(0, 3);
      ticks(3);
      op(1'b1, 1'b0, 0, 3, 1'b1, d);
      @(negedge clk);
      chk("R9 write wins irq", cpu_irq[0], 1'b0);
      rd(1, d); chk("R9 write wins count", d, fmt(1'b0, 0));
      wr(0, 3);
      ticks(3);
      op(1'b1, 1'b0, 2, 3, 1'b1, d);
      @(negedge clk);
      chk("R9 keep wins irq", cpu_irq[0], 1'b0);

      // R10: mode bit 0 stops timer 0 compare, timer 1 unaffected
      wr(12, 1);
      rd(12, d); chk("R10 mode readback", d, 1);
      wr(0, 2);
      wr(4, 2);
      ticks(10);
      @(negedge clk);
      chk("R10 cpu0 quiet", cpu_irq[0], 1'b0);
      chk("R10 cpu1 fires", cpu_irq[1], 1'b1);
      rd(1, d); chk("R10 cpu0 free count", d, fmt(1'b0, 10));
      wr(12, 0);
      rd(12, d); chk("R10 mode cleared", d, 0);
      wr(0, 2);
      ticks(3);
      @(negedge clk);
      chk("R10 compare back", cpu_irq[0], 1'b1);

      // R1: aux, reserved, keep alias and unmapped words
      wr(0, 7); wr(4, 6); wr(8, 5);
      for (int u = 0; u < NU; u++) begin
         wr(4*u + 3, 32'hFF);
         rd(4*u + 3, d); chk("R1 aux reads 0", d, 0);
         rd(4*u + 2, d); chk("R1 keep reads 0", d, 0);
         rd(4*u, d);     chk("R1 limit intact", d, fmt(1'b0, 7 - u));
      end
      for (int a = 13; a < 16; a++) begin
         wr(a, 32'h3);
         rd(a, d); chk("R1 unmapped", d, 0);
      end
      rd(12, d); chk("R1 mode intact", d, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule